// File: doc/BRIEF.md
# Scan Test Point Enable Sequencer

This controller drives a scan test session on a chip whose scan cells carry output-hold test points. These are gates that pin a scan cell's output to a constant while the chain shifts, so shifting injects fewer transitions into the logic behind the cells. For every pattern the sequencer shifts a programmed number of cycles and then runs one capture cycle. It repeats this for a programmed number of patterns. After the last capture it runs one final unload shift and reports completion.

Two schemes are available, and the choice is sampled at start. In the tied scheme the test point enable simply follows the scan enable, and no cycles are added. In the split scheme a quiet cycle with no clock is placed before capture, so the test points are released there, after the last shift. A second quiet cycle is placed after capture, so the test points are re-armed there, before the next shift. This keeps the release and re-arm transitions out of any cycle that also shifts. The cost is two cycles per capture.

The block has three strobe outputs: scan enable, test point enable and a functional clock enable. It also drives a phase code and a done flag.

Top module: `scan_tp_seq`

## Requirements
- R1: After reset the phase is idle (code 0), and scan enable, test point enable, clock enable and done are all low.
- R2: Every shift cycle (phase code 1) drives scan enable, test point enable and clock enable high.
- R3: Each pattern's shifts are followed by exactly one capture cycle (phase code 3), with scan enable low, test point enable low and clock enable high.
- R4: In the tied scheme (mode 0), test point enable equals scan enable in every cycle, and capture directly follows the last shift of a pattern.
- R5: In the split scheme (mode 1), the cycle after the last shift of a pattern is a release cycle (phase code 2) with all three strobes low, and it is followed by capture.
- R6: In the split scheme, the cycle after capture is a re-arm cycle (phase code 4): test point enable high, scan enable low, clock enable low. It is followed by the first shift of the next pattern or of the unload.
- R7: With chain length L and pattern count N (both non-zero), done rises in the cycle after the cycles of the run. A run lasts (N+1)*L + N cycles in the tied scheme and (N+1)*L + 3*N cycles in the split scheme.
- R8: After the last pattern's capture (and re-arm, in the split scheme), L unload shifts follow. Then the phase becomes done (code 5): done is high and all strobes are low. This holds until the next accepted start.
- R9: A start with chain length 0 or pattern count 0 gives the done phase in the next cycle, with no shift cycle.
- R10: The phase output codes are: idle 0, shift 1, release 2, capture 3, re-arm 4, done 5.
- R11: Start is accepted only in the idle or done phase. Chain length, pattern count and mode are sampled at the accepted start. Changing them, or pulsing start, during a run has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in idle or done) |
| chain_len | input | LEN_W | Shift cycles per pattern |
| pat_count | input | PAT_W | Number of patterns |
| mode | input | 1 | 0 = tied scheme, 1 = split scheme |
| scan_en | output | 1 | Scan enable |
| tp_en | output | 1 | Test point enable |
| clk_en | output | 1 | Functional clock enable |
| phase | output | 3 | Current phase code |
| done | output | 1 | Run complete |

## Verification
Every output is decoded directly from the phase register. A start sampled at a clock edge therefore appears in the outputs right after that edge: the first shift, or the done phase for an empty run, arrives one cycle after start. From then on, each later cycle's expected phase follows from its offset within a pattern slot of L+1 or L+3 cycles. The bench numbers the cycles from the edge that takes the start. It samples on the falling edge, where every register on the way has settled. It compares each cycle against a phase computed from that offset.

// File: rtl/scan_tp_pkg.sv
package scan_tp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SHIFT   = 3'd1,
    PH_RELEASE = 3'd2,
    PH_CAPTURE = 3'd3,
    PH_REARM   = 3'd4,
    PH_DONE    = 3'd5
  } phase_e;

  typedef struct packed {
    logic scan_en;
    logic tp_en;
    logic clk_en;
    logic done;
  } strobe_t;

  // Strobe pattern owned by each phase.
  function automatic strobe_t strobes_for(phase_e ph);
    strobe_t s;
    s = '0;
    case (ph)
      PH_SHIFT:   begin s.scan_en = 1'b1; s.tp_en = 1'b1; s.clk_en = 1'b1; end
      PH_CAPTURE: s.clk_en = 1'b1;
      PH_REARM:   s.tp_en  = 1'b1;
      PH_DONE:    s.done   = 1'b1;
      default:    s = '0;
    endcase
    return s;
  endfunction

  // Phase that follows the last shift of a loading pass.
  function automatic phase_e after_last_shift(logic unload, logic split);
    if (unload) return PH_DONE;
    return split ? PH_RELEASE : PH_CAPTURE;
  endfunction

  // Phase that follows a capture cycle.
  function automatic phase_e after_capture(logic split);
    return split ? PH_REARM : PH_SHIFT;
  endfunction

endpackage

// File: rtl/tp_step_counter.sv
module tp_step_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/tp_phase_fsm.sv
module tp_phase_fsm
  import scan_tp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   empty_run,
  input  logic   shift_last,
  input  logic   unload,
  input  logic   split,
  output phase_e phase_q
);
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE, PH_DONE: if (start) phase_d = empty_run ? PH_DONE : PH_SHIFT;
      PH_SHIFT:         if (shift_last) phase_d = after_last_shift(unload, split);
      PH_RELEASE:       phase_d = PH_CAPTURE;
      PH_CAPTURE:       phase_d = after_capture(split);
      PH_REARM:         phase_d = PH_SHIFT;
      default:          phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/tp_strobe_decode.sv
module tp_strobe_decode
  import scan_tp_pkg::*;
(
  input  phase_e phase_q,
  output logic   scan_en,
  output logic   tp_en,
  output logic   clk_en,
  output logic   done
);
  strobe_t s;
  always_comb begin
    s       = strobes_for(phase_q);
    scan_en = s.scan_en;
    tp_en   = s.tp_en;
    clk_en  = s.clk_en;
    done    = s.done;
  end
endmodule

// File: rtl/scan_tp_seq.sv
module scan_tp_seq
  import scan_tp_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int PAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] chain_len,
  input  logic [PAT_W-1:0] pat_count,
  input  logic             mode,
  output logic             scan_en,
  output logic             tp_en,
  output logic             clk_en,
  output logic [2:0]       phase,
  output logic             done
);
  localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  phase_e           phase_q;
  logic [LEN_W-1:0] len_q;
  logic [PAT_W-1:0] cnt_q;
  logic             mode_q;
  logic [LEN_W-1:0] shift_cnt;
  logic [PAT_W-1:0] pat_cnt;

  // Named internal events, visible to the checker.
  logic start_take, empty_run, in_shift, shift_last, capture_fire, unload;

  assign start_take   = start && (phase_q == PH_IDLE || phase_q == PH_DONE);
  assign empty_run    = (chain_len == '0) || (pat_count == '0);
  assign in_shift     = (phase_q == PH_SHIFT);
  assign shift_last   = in_shift && (shift_cnt == len_q - LEN_ONE);
  assign capture_fire = (phase_q == PH_CAPTURE);
  assign unload       = (pat_cnt == cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (start_take) begin
      len_q  <= chain_len;
      cnt_q  <= pat_count;
      mode_q <= mode;
    end
  end

  tp_step_counter #(.W(LEN_W)) shift_ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_take || shift_last),
    .step  (in_shift),
    .count (shift_cnt)
  );

  tp_step_counter #(.W(PAT_W)) pat_ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_take),
    .step  (capture_fire),
    .count (pat_cnt)
  );

  tp_phase_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .empty_run  (empty_run),
    .shift_last (shift_last),
    .unload     (unload),
    .split      (mode_q),
    .phase_q    (phase_q)
  );

  tp_strobe_decode dec_i (
    .phase_q (phase_q),
    .scan_en (scan_en),
    .tp_en   (tp_en),
    .clk_en  (clk_en),
    .done    (done)
  );

  assign phase = phase_q;
endmodule

// File: rtl/scan_tp_seq_chk.sv
module scan_tp_seq_chk #(
  parameter int LEN_W = 6,
  parameter int PAT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] chain_len,
  input logic [PAT_W-1:0] pat_count,
  input logic [2:0]       phase,
  input logic             scan_en,
  input logic             tp_en,
  input logic             clk_en,
  input logic             done,
  input logic             mode_q
);
  logic in_run;
  assign in_run = (phase >= 3'd1) && (phase <= 3'd4);

  assert_shift_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |-> (scan_en && tp_en && clk_en));

  assert_capture_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3) |-> (!scan_en && !tp_en && clk_en));

  assert_tied_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && in_run) |-> (tp_en == scan_en));

  // R5/R6: in the split scheme the test point enable toggles only in unclocked cycles
  assert_split_quiet_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && in_run && $past(in_run) && (tp_en != $past(tp_en))) |-> !clk_en);

  assert_release_to_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |=> (phase == 3'd3));

  assert_rearm_to_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) |=> (phase == 3'd1));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scan_en && !tp_en && !clk_en));

  assert_empty_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (phase == 3'd0 || phase == 3'd5) && (chain_len == '0 || pat_count == '0))
      |=> (phase == 3'd5 && done));

  assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && phase != 3'd1) |=> (phase != 3'd0));
endmodule

bind scan_tp_seq scan_tp_seq_chk #(.LEN_W(LEN_W), .PAT_W(PAT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .chain_len (chain_len),
  .pat_count (pat_count),
  .phase     (phase),
  .scan_en   (scan_en),
  .tp_en     (tp_en),
  .clk_en    (clk_en),
  .done      (done),
  .mode_q    (mode_q)
);

// File: tb/scan_tp_seq_tb_top.sv
`timescale 1ns/1ps
module scan_tp_seq_tb_top;
  localparam int LEN_W = 6;
  localparam int PAT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] chain_len = '0;
  logic [PAT_W-1:0] pat_count = '0;
  logic             mode = 1'b0;
  logic             scan_en, tp_en, clk_en, done;
  logic [2:0]       phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  scan_tp_seq #(.LEN_W(LEN_W), .PAT_W(PAT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_len(chain_len),
    .pat_count(pat_count), .mode(mode), .scan_en(scan_en), .tp_en(tp_en),
    .clk_en(clk_en), .phase(phase), .done(done)
  );

  // Expected phase code in cycle k after the start edge (R10 codes).
  function automatic int exp_phase(int k, int len, int n, bit split);
    int slot, pos, tail;
    if (len == 0 || n == 0) return 5;
    slot = len + (split ? 3 : 1);
    if (k < n * slot) begin
      pos = k % slot;
      if (pos < len) return 1;
      if (!split) return 3;
      if (pos == len) return 2;
      if (pos == len + 1) return 3;
      return 4;
    end
    tail = k - n * slot;
    return (tail < len) ? 1 : 5;
  endfunction

  function automatic int run_length(int len, int n, bit split);
    if (len == 0 || n == 0) return 0;
    return (n + 1) * len + n * (split ? 3 : 1);
  endfunction

  // {scan_en, tp_en, clk_en, done} expected for a phase code.
  function automatic logic [3:0] exp_bits(int ph);
    case (ph)
      1: return 4'b1110;
      2: return 4'b0000;
      3: return 4'b0010;
      4: return 4'b0100;
      5: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic run(int len, int n, bit split, bit poke);
    int total, ph;
    string tag;
    logic [3:0] got;
    total = run_length(len, n, split);
    @(negedge clk);
    chain_len = LEN_W'(len); pat_count = PAT_W'(n); mode = split; start = 1'b1;
    for (int k = 0; k <= total + 2; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == 0) begin
        // scramble settings mid-run: must be ignored (R11)
        chain_len = LEN_W'($urandom); pat_count = PAT_W'($urandom); mode = ~split;
      end
      ph = exp_phase(k, len, n, split);
      case (ph)
        1: tag = "R2/R11";
        2: tag = "R5";
        3: tag = "R3";
        4: tag = "R6";
        default: tag = (total == 0) ? "R9" : "R8";
      endcase
      check(int'(phase) == ph, {tag, " phase R10"}, int'(phase), ph);
      got = {scan_en, tp_en, clk_en, done};
      check(got == exp_bits(ph), {tag, " strobes"}, int'(got), int'(exp_bits(ph)));
      if (!split && k < total) check(tp_en == scan_en, "R4 tied", int'(tp_en), int'(scan_en));
      if (k == total) check(done == 1'b1, "R7 run length", int'(done), 1);
      if (poke && k < total && (k % 5) == 2) start = 1'b1;  // ignored in run (R11)
    end
  endtask

  initial begin
    int len, n;
    bit sp;
    void'($urandom(32'h5CA7_0001));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(phase == 3'd0, "R1 reset phase", int'(phase), 0);
    check({scan_en, tp_en, clk_en, done} == 4'b0, "R1 reset strobes",
          int'({scan_en, tp_en, clk_en, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase == 3'd0, "R1 idle hold", int'(phase), 0);

    run(1, 1, 1'b0, 1'b0);
    run(1, 1, 1'b1, 1'b0);
    run(3, 2, 1'b1, 1'b1);
    run(4, 3, 1'b0, 1'b1);
    run(0, 3, 1'b1, 1'b0);
    run(5, 0, 1'b0, 1'b0);
    run(63, 2, 1'b1, 1'b0);
    run(2, 15, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++) begin
      len = $urandom_range(0, 12);
      n   = $urandom_range(0, 5);
      sp  = 1'($urandom_range(0, 1));
      run(len, n, sp, 1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule